// File: doc/BRIEF.md
# Infrared Raw Pulse-Width Receiver

This block watches a demodulated infrared line and turns its activity into raw timing data. The line rests high. Each falling edge starts a symbol. The block counts how long the line stays low, then how long it stays high, in units of 10 µs. When the next falling edge arrives, it stores the pair as one 32-bit word in a first-in first-out queue. If the line stays high long enough that the low and high counts together reach a programmed maximum width, the symbol is closed as the last of the stream, a timeout is flagged, and the block waits for the next falling edge.

Software reaches the block through a simple word-addressed register port. It turns the receiver on, waits for the short initialisation to finish, and starts capture with a write. It then reads the queue occupancy and pops symbols one read at a time. Three status sources can drive the single interrupt line: enough symbols received, end-of-stream timeout, and queue overflow. Each source can be masked and cleared on its own. On overflow the stored words stay untouched until software has read them all.

Top module: `ir_pulse_rx`

## Requirements
- R1: After reset the enable, busy, count, status and data registers read 0, the mask register reads 0x0000_0700, and `irq` is low.
- R2: Writing 1 to the enable register (byte offset 0x00, bit 0) makes the busy register (0x1C) read 1 for INIT_CYCLES clock cycles. A write to the start register (0x34) begins capture only if the block is enabled and not busy. Writing 0 to enable stops capture.
- R3: With the prescaler field at 0, one count unit is 10 clock cycles. A stored word holds the low-phase count in bits [15:0] and the high-phase count in bits [31:16].
- R4: The prescaler field (config 0x04, bits [6:0]) divides the clock by the field value plus one to form the 1 µs tick, so each count unit is 10·(field+1) cycles.
- R5: In the high phase, once the low count plus the high count reaches the width field (config bits [31:16]), the symbol is stored with the high count equal to width minus low. Status bit 9 and bit 25 are then set, and capture waits for a new falling edge.
- R6: The count register (0x20) returns the number of stored words. Each read of the data register (0x24) returns the oldest word and removes it. A read of 0x24 while the queue is empty returns 0 and changes nothing.
- R7: Status bit 8 and bit 24 are set when a store leaves the occupancy greater than the level field (config bits [13:8]).
- R8: A store attempted while DEPTH words are held sets status bit 10 and bit 26 and leaves the stored words unchanged. A clear of this bit has no effect while the count is nonzero.
- R9: Writing 1 to bit 16, 17 or 18 of the clear register (0x30) clears status bit 8, 9 or 10 respectively, together with its mirror bit.
- R10: `irq` is high exactly when some status bit among 8, 9 and 10 is set while the mask register (0x28) holds 0 in the same bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared line, idles high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the queue at 0x24 |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Interrupt request, active high |

## Verification
A counter that is off by even one unit appears in the first word popped, after one symbol period plus the sync delay. A wrong phase sequence shows up as swapped or merged halves of that same word. Queue pointer or occupancy faults show in the count register and in the order of popped words as soon as the queue is read. If the overflow path overwrites entries, the bench finds a wrong first word after the overflow, and it finds a wrong count after the queue is drained. Status and mask faults show on `irq` in the cycle after the register write that exposes them.

// File: rtl/ir_pulse_rx.sv
module ir_pulse_rx #(
  parameter int DEPTH       = 64,
  parameter int INIT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int IW = $clog2(INIT_CYCLES + 1);

  localparam logic [5:0] A_EN  = 6'h00, A_CFG = 6'h04, A_BUSY = 6'h1C, A_CNT = 6'h20,
                         A_DAT = 6'h24, A_MSK = 6'h28, A_ST   = 6'h2C, A_CLR = 6'h30,
                         A_GO  = 6'h34;

  typedef enum logic [1:0] {WAIT_FALL, PH_LOW, PH_HIGH} phase_t;

  logic          en_q, run_q;
  logic [31:0]   cfg_q;
  logic [IW-1:0] busy_cnt;
  logic [2:0]    mask_q, st_q;
  logic          s1, s2, s_d;
  phase_t        ph;
  logic [6:0]    pre_cnt;
  logic [3:0]    dec_cnt;
  logic [15:0]   lo_cnt, hi_cnt;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx;

  wire busy   = busy_cnt != '0;
  wire fall   = s_d & ~s2;
  wire rise   = ~s_d & s2;
  wire tick   = pre_cnt == cfg_q[6:0];
  wire unit   = tick && dec_cnt == 4'd9;
  wire tmo_hit = ({1'b0, lo_cnt} + {1'b0, hi_cnt}) >= {1'b0, cfg_q[31:16]};
  wire push   = run_q && ph == PH_HIGH && (tmo_hit || fall);
  wire full   = cnt == CW'(DEPTH);
  wire empty  = cnt == '0;
  wire do_push = push && !full;
  wire pop    = reg_rd && reg_addr == A_DAT && !empty;
  wire phase_rst = run_q && ((ph == WAIT_FALL && fall) || (ph == PH_LOW && rise) ||
                             (ph == PH_HIGH && fall && !tmo_hit));

  assign cnt_nx = cnt + CW'(do_push) - CW'(pop);
  assign irq    = |(st_q & ~mask_q);

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = {31'b0, en_q};
      A_CFG:   reg_rdata = cfg_q;
      A_BUSY:  reg_rdata = {31'b0, busy};
      A_CNT:   reg_rdata = 32'(cnt);
      A_DAT:   reg_rdata = empty ? 32'b0 : mem[rp];
      A_MSK:   reg_rdata = {21'b0, mask_q, 8'b0};
      A_ST:    reg_rdata = {5'b0, st_q, 13'b0, st_q, 8'b0};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      run_q    <= 1'b0;
      busy_cnt <= '0;
      cfg_q    <= 32'h3E80_0080;
      mask_q   <= 3'b111;
    end else begin
      if (busy) busy_cnt <= busy_cnt - IW'(1);
      if (reg_wr) begin
        case (reg_addr)
          A_EN: begin
            en_q <= reg_wdata[0];
            busy_cnt <= reg_wdata[0] ? IW'(INIT_CYCLES) : '0;
            if (!reg_wdata[0]) run_q <= 1'b0;
          end
          A_CFG: cfg_q  <= reg_wdata;
          A_MSK: mask_q <= reg_wdata[10:8];
          A_GO:  if (en_q && !busy) run_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s_d <= 1'b1;
    end else begin
      s1 <= ir_in;
      s2 <= s1;
      s_d <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      dec_cnt <= '0;
    end else if (phase_rst || !run_q) begin
      pre_cnt <= '0;
      dec_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      dec_cnt <= (dec_cnt == 4'd9) ? 4'd0 : dec_cnt + 4'd1;
    end else begin
      pre_cnt <= pre_cnt + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= WAIT_FALL;
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (!run_q) begin
      ph <= WAIT_FALL;
    end else begin
      case (ph)
        WAIT_FALL: if (fall) begin
          ph <= PH_LOW;
          lo_cnt <= '0;
          hi_cnt <= '0;
        end
        PH_LOW:
          if (rise) ph <= PH_HIGH;
          else if (unit && lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 16'd1;
        PH_HIGH:
          if (tmo_hit) ph <= WAIT_FALL;
          else if (fall) begin
            ph <= PH_LOW;
            lo_cnt <= '0;
            hi_cnt <= '0;
          end else if (unit) hi_cnt <= hi_cnt + 16'd1;
        default: ph <= WAIT_FALL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {hi_cnt, lo_cnt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      st_q <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (pop)     rp <= rp + AW'(1);
      cnt <= cnt_nx;
      if (reg_wr && reg_addr == A_CLR) begin
        if (reg_wdata[16]) st_q[0] <= 1'b0;
        if (reg_wdata[17]) st_q[1] <= 1'b0;
        if (reg_wdata[18] && empty) st_q[2] <= 1'b0;
      end
      if (do_push && 32'(cnt_nx) > 32'(cfg_q[13:8])) st_q[0] <= 1'b1;
      if (push && tmo_hit) st_q[1] <= 1'b1;
      if (push && full)    st_q[2] <= 1'b1;
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_pop_takes_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !do_push) |=> (cnt == $past(cnt) - CW'(1)));
  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == CW'(DEPTH) && st_q[2]));
  p_tmo_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && tmo_hit) |=> (st_q[1] && ph == WAIT_FALL));
  p_busy_blocks_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(run_q));
endmodule

// File: tb/ir_pulse_rx_test.sv
`timescale 1ns/1ps
module ir_pulse_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  ir_pulse_rx uut (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
                   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic sym(input int lo_cyc, input int hi_cyc);
    @(negedge clk); ir_in = 1'b0;
    repeat (lo_cyc) @(negedge clk);
    ir_in = 1'b1;
    repeat (hi_cyc) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h00, d); check("R1 enable", d, 0);
    rd(6'h1C, d); check("R1 busy", d, 0);
    rd(6'h20, d); check("R1 count", d, 0);
    rd(6'h2C, d); check("R1 status", d, 0);
    rd(6'h28, d); check("R1 mask", d, 32'h0000_0700);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(6'h00, 1);
    rd(6'h1C, d); check("R2 busy after enable", d, 1);
    wr(6'h34, 1);
    repeat (20) @(negedge clk);
    rd(6'h1C, d); check("R2 busy done", d, 0);
    sym(35, 55); sym(35, 55);
    repeat (400) @(negedge clk);
    rd(6'h20, d); check("R2 start while busy ignored", d, 0);
    wr(6'h04, {16'd30, 2'b0, 6'd0, 1'b1, 7'd0});
    wr(6'h34, 1);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    sym(35, 55); sym(25, 45); sym(15, 25);
    repeat (400) @(negedge clk);
    rd(6'h20, d); check("R6 count", d, 3);
    rd(6'h2C, d); check("R7 R5 status", d, 32'h0300_0300);
    check("R10 irq masked", {31'b0, irq}, 0);
    wr(6'h28, 0);
    check("R10 irq unmasked", {31'b0, irq}, 1);
    rd(6'h24, d); check("R3 word 1", d, 32'h0005_0003);
    rd(6'h24, d); check("R3 word 2", d, 32'h0004_0002);
    rd(6'h24, d); check("R5 timeout word", d, 32'h001D_0001);
    rd(6'h24, d); check("R6 empty pop", d, 0);
    rd(6'h20, d); check("R6 count after drain", d, 0);
    wr(6'h30, 32'h0001_0000);
    rd(6'h2C, d); check("R9 clear received", d, 32'h0200_0200);
    check("R10 irq timeout only", {31'b0, irq}, 1);
    wr(6'h28, 32'h0000_0200);
    check("R10 irq timeout masked", {31'b0, irq}, 0);
    wr(6'h30, 32'h0002_0000);
    rd(6'h2C, d); check("R9 clear timeout", d, 0);
    wr(6'h28, 0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(6'h04, {16'd30, 2'b0, 6'd0, 1'b1, 7'd1});
    sym(45, 65); sym(45, 10);
    repeat (800) @(negedge clk);
    rd(6'h20, d); check("R4 count", d, 2);
    rd(6'h24, d); check("R4 word", d, 32'h0003_0002);
    rd(6'h24, d); check("R4 timeout word", d, 32'h001C_0002);
    wr(6'h30, 32'h0007_0000);
    wr(6'h04, {16'd30, 2'b0, 6'd0, 1'b1, 7'd0});
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    for (int i = 0; i < 66; i++) sym(15, 15);
    repeat (400) @(negedge clk);
    rd(6'h20, d); check("R8 count full", d, 64);
    rd(6'h2C, d); check("R8 overflow status", d & 32'h0400_0400, 32'h0400_0400);
    wr(6'h30, 32'h0004_0000);
    rd(6'h2C, d); check("R8 clear ignored while stored", d & 32'h0400_0400, 32'h0400_0400);
    rd(6'h24, d); check("R8 first word kept", d, 32'h0001_0001);
    for (int i = 0; i < 62; i++) rd(6'h24, d);
    rd(6'h24, d); check("R8 last word kept", d, 32'h0001_0001);
    rd(6'h20, d); check("R8 drained", d, 0);
    wr(6'h30, 32'h0007_0000);
    rd(6'h2C, d); check("R9 overflow cleared", d, 0);
    check("R10 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(6'h00, 0);
    wr(6'h34, 1);
    sym(35, 55); sym(35, 55);
    repeat (400) @(negedge clk);
    rd(6'h20, d); check("R2 disabled no capture", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_capture();
    t_prescale();
    t_overflow();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule